// File: doc/BRIEF.md
# Register Readiness Scoreboard with Consumer Wakeup

This block tracks whether each physical register holds a valid result. It also holds a small table of dispatched instructions that are still waiting for source operands. The dispatch stage presents one instruction per cycle: an optional destination register, up to two optional source registers, a tag, a thread number and a sequence number.

Each source is checked against the scoreboard as it arrives, so a value that was produced while the instruction was in flight is not waited for again. When an execution unit announces a completed register, the block sets that register's ready bit. It also marks the register ready in every waiting table entry that names it.

Any entry whose sources are all ready is sent to the issue logic as a one-cycle ready pulse, one per cycle, and its slot is freed. A squash for one thread drops that thread's waiting entries that are younger than a given sequence number. The block does not select functional units and does not execute anything.

Top module: `regwake_scoreboard`

## Requirements
- R1: After reset, every bit of `sb_ready` is 0, `rdy_valid` is 0 and `disp_stall` is 0.
- R2: An accepted dispatch with `disp_dst_en`=1 and `disp_dst` below NPREG (default 32) clears `sb_ready[disp_dst]`, visible the cycle after.
- R3: `cmpl_valid`=1 with `cmpl_reg` below NPREG sets `sb_ready[cmpl_reg]`, visible the cycle after.
- R4: A register index of NPREG or above (6-bit index field by default) never changes `sb_ready` and counts as a ready source.
- R5: A dispatched instruction whose enabled sources are all ready at dispatch produces `rdy_valid`=1 with its tag, thread and sequence number two clock edges after the dispatch edge.
- R6: A waiting entry stays silent until every one of its sources has been completed. It pulses `rdy_valid` on the edge after the completion that made it ready.
- R7: A completion and a dispatch reading the same register in the same cycle count that source as ready at dispatch.
- R8: A squash (`sq_valid`=1) removes exactly the entries of thread `sq_tid` whose sequence number is strictly greater than `sq_seq`. An entry with an equal sequence number, or of another thread, stays.
- R9: `disp_stall` is 1 when all DEPTH (default 8) slots are occupied. A dispatch presented while stalled is ignored, including its destination clear.
- R10: At most one entry is emitted per cycle. Slots are allocated lowest-free-first and the lowest ready slot is emitted first, so an empty table emits simultaneously woken entries in dispatch order.
- R11: When a dispatch destination and a completion name the same register in the same cycle, the register ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Instruction tag |
| disp_tid | input | TID_W | Thread number |
| disp_seq | input | SEQ_W | Sequence number (larger is younger) |
| disp_dst_en | input | 1 | Destination present |
| disp_dst | input | REG_W | Destination register index |
| disp_src0_en | input | 1 | First source present |
| disp_src0 | input | REG_W | First source register index |
| disp_src1_en | input | 1 | Second source present |
| disp_src1 | input | REG_W | Second source register index |
| disp_stall | output | 1 | Wait table full, dispatch not accepted |
| cmpl_valid | input | 1 | Completion broadcast |
| cmpl_reg | input | REG_W | Completed register index |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries younger than this are dropped |
| rdy_valid | output | 1 | Ready pulse |
| rdy_tag | output | TAG_W | Tag of the ready instruction |
| rdy_tid | output | TID_W | Thread of the ready instruction |
| rdy_seq | output | SEQ_W | Sequence number of the ready instruction |
| sb_ready | output | NPREG | Scoreboard ready bits |

## Verification
On every cycle, the assertions check several properties. A tracked destination clear or completion lands in the next cycle's scoreboard, with the clear winning on a same-register collision. Out-of-range completions leave the scoreboard alone. Squash-hit slots are gone the next cycle, the emit grant is at most one-hot, and stall implies a full table that a stalled dispatch cannot grow.

Only the bench scenarios can show the end-to-end timing of ready pulses and the forwarding of a same-cycle completion into dispatch. They also cover the exact set of entries that survive a squash and the emission order of a full table released by one completion.

// File: rtl/rwsb_pkg.sv
package rwsb_pkg;
  // A register index is tracked only when it lies inside the physical range.
  function automatic logic reg_tracked(input logic [31:0] idx, input int unsigned npreg);
    return idx < npreg;
  endfunction

  // Sequence numbers grow with program order; larger means younger.
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction

  // A source counts as ready when absent, untracked, already set, or forwarded.
  function automatic logic src_ok(input logic en, input logic trk, input logic bit_set,
                                  input logic fwd);
    return !en || !trk || bit_set || fwd;
  endfunction
endpackage

// File: rtl/rwsb_pick.sv
module rwsb_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rwsb_board.sv
module rwsb_board
  import rwsb_pkg::*;
#(
  parameter int unsigned NPREG = 32,
  parameter int unsigned REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic             rd0_en,
  input  logic [REG_W-1:0] rd0_idx,
  input  logic             rd1_en,
  input  logic [REG_W-1:0] rd1_idx,
  output logic [NPREG-1:0] bits,
  output logic             rd0_rdy,
  output logic             rd1_rdy
);
  localparam int unsigned IDX_W = (NPREG > 1) ? $clog2(NPREG) : 1;

  logic             clr_trk, set_trk, rd0_trk, rd1_trk;
  logic [IDX_W-1:0] clr_i, set_i, rd0_i, rd1_i;
  logic             rd0_fwd, rd1_fwd;

  assign clr_trk = reg_tracked(32'(clr_idx), NPREG);
  assign set_trk = reg_tracked(32'(set_idx), NPREG);
  assign rd0_trk = reg_tracked(32'(rd0_idx), NPREG);
  assign rd1_trk = reg_tracked(32'(rd1_idx), NPREG);
  assign clr_i   = clr_idx[IDX_W-1:0];
  assign set_i   = set_idx[IDX_W-1:0];
  assign rd0_i   = rd0_idx[IDX_W-1:0];
  assign rd1_i   = rd1_idx[IDX_W-1:0];

  // Same-cycle completion is forwarded to the dispatch read.
  assign rd0_fwd = set_en && set_trk && (set_idx == rd0_idx);
  assign rd1_fwd = set_en && set_trk && (set_idx == rd1_idx);
  assign rd0_rdy = src_ok(rd0_en, rd0_trk, rd0_trk && bits[rd0_i], rd0_fwd);
  assign rd1_rdy = src_ok(rd1_en, rd1_trk, rd1_trk && bits[rd1_i], rd1_fwd);

  // Clear is written after set, so a new producer wins a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      if (set_en && set_trk) bits[set_i] <= 1'b1;
      if (clr_en && clr_trk) bits[clr_i] <= 1'b0;
    end
  end

  // R2 and R11: a tracked destination clear always lands.
  p_dst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_trk) |=> !bits[$past(clr_i)]);

  // R3: an uncontested tracked completion always lands.
  p_cmpl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_trk && !(clr_en && clr_trk && clr_i == set_i)) |=> bits[$past(set_i)]);
endmodule

// File: rtl/rwsb_table.sv
module rwsb_table
  import rwsb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned REG_W = 6,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned TID_W = 1,
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DEPTH-1:0] wr_slot,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [REG_W-1:0] wr_src0,
  input  logic             wr_rdy0,
  input  logic [REG_W-1:0] wr_src1,
  input  logic             wr_rdy1,
  input  logic             wake_en,
  input  logic [REG_W-1:0] wake_idx,
  input  logic             sq_en,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [DEPTH-1:0] emit_gnt,
  output logic [DEPTH-1:0] valid,
  output logic [DEPTH-1:0] ready,
  output logic [TAG_W-1:0] em_tag,
  output logic [TID_W-1:0] em_tid,
  output logic [SEQ_W-1:0] em_seq
);
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [TID_W-1:0] tid_q  [DEPTH];
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [REG_W-1:0] src0_q [DEPTH];
  logic [REG_W-1:0] src1_q [DEPTH];
  logic [DEPTH-1:0] rdy0_q, rdy1_q, sq_hit, wake0, wake1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign sq_hit[g] = sq_en && valid[g] && (tid_q[g] == sq_tid) &&
                       seq_younger(32'(seq_q[g]), 32'(sq_seq));
    assign wake0[g]  = wake_en && (src0_q[g] == wake_idx);
    assign wake1[g]  = wake_en && (src1_q[g] == wake_idx);
    assign ready[g]  = valid[g] && rdy0_q[g] && rdy1_q[g] && !sq_hit[g];

    // R8: a slot hit by a squash is empty on the next cycle.
    p_squash_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sq_hit[g] |=> !valid[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= '0;
      rdy0_q <= '0;
      rdy1_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_slot[i]) begin
          valid[i]  <= 1'b1;
          rdy0_q[i] <= wr_rdy0;
          rdy1_q[i] <= wr_rdy1;
        end else if (valid[i]) begin
          if (emit_gnt[i] || sq_hit[i]) begin
            valid[i] <= 1'b0;
          end else begin
            if (wake0[i]) rdy0_q[i] <= 1'b1;
            if (wake1[i]) rdy1_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && wr_slot[i]) begin
        tag_q[i]  <= wr_tag;
        tid_q[i]  <= wr_tid;
        seq_q[i]  <= wr_seq;
        src0_q[i] <= wr_src0;
        src1_q[i] <= wr_src1;
      end
    end
  end

  always_comb begin
    em_tag = '0;
    em_tid = '0;
    em_seq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (emit_gnt[i]) begin
        em_tag = em_tag | tag_q[i];
        em_tid = em_tid | tid_q[i];
        em_seq = em_seq | seq_q[i];
      end
    end
  end
endmodule

// File: rtl/regwake_scoreboard.sv
module regwake_scoreboard
  import rwsb_pkg::*;
#(
  parameter int unsigned NPREG = 32,
  parameter int unsigned REG_W = 6,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned TID_W = 1,
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic [TID_W-1:0] disp_tid,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             disp_dst_en,
  input  logic [REG_W-1:0] disp_dst,
  input  logic             disp_src0_en,
  input  logic [REG_W-1:0] disp_src0,
  input  logic             disp_src1_en,
  input  logic [REG_W-1:0] disp_src1,
  output logic             disp_stall,
  input  logic             cmpl_valid,
  input  logic [REG_W-1:0] cmpl_reg,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             rdy_valid,
  output logic [TAG_W-1:0] rdy_tag,
  output logic [TID_W-1:0] rdy_tid,
  output logic [SEQ_W-1:0] rdy_seq,
  output logic [NPREG-1:0] sb_ready
);
  logic [DEPTH-1:0] wt_valid, free_gnt, emit_req, emit_gnt;
  logic             free_any, emit_any;
  logic             s0_rdy, s1_rdy, cmpl_trk;
  logic             disp_fire, disp_drop, wr_en, dst_clr;
  logic [TAG_W-1:0] em_tag;
  logic [TID_W-1:0] em_tid;
  logic [SEQ_W-1:0] em_seq;

  assign cmpl_trk   = cmpl_valid && reg_tracked(32'(cmpl_reg), NPREG);
  assign disp_stall = !free_any;
  assign disp_fire  = disp_valid && free_any;
  assign disp_drop  = sq_valid && (disp_tid == sq_tid) &&
                      seq_younger(32'(disp_seq), 32'(sq_seq));
  assign wr_en      = disp_fire && !disp_drop;
  assign dst_clr    = wr_en && disp_dst_en;

  rwsb_board #(.NPREG(NPREG), .REG_W(REG_W)) u_board (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (dst_clr),
    .clr_idx (disp_dst),
    .set_en  (cmpl_valid),
    .set_idx (cmpl_reg),
    .rd0_en  (disp_src0_en),
    .rd0_idx (disp_src0),
    .rd1_en  (disp_src1_en),
    .rd1_idx (disp_src1),
    .bits    (sb_ready),
    .rd0_rdy (s0_rdy),
    .rd1_rdy (s1_rdy)
  );

  rwsb_pick #(.N(DEPTH)) u_free (
    .req (~wt_valid),
    .gnt (free_gnt),
    .any (free_any)
  );

  rwsb_table #(.DEPTH(DEPTH), .REG_W(REG_W), .TAG_W(TAG_W), .TID_W(TID_W),
               .SEQ_W(SEQ_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (free_gnt),
    .wr_tag   (disp_tag),
    .wr_tid   (disp_tid),
    .wr_seq   (disp_seq),
    .wr_src0  (disp_src0),
    .wr_rdy0  (s0_rdy),
    .wr_src1  (disp_src1),
    .wr_rdy1  (s1_rdy),
    .wake_en  (cmpl_trk),
    .wake_idx (cmpl_reg),
    .sq_en    (sq_valid),
    .sq_tid   (sq_tid),
    .sq_seq   (sq_seq),
    .emit_gnt (emit_gnt),
    .valid    (wt_valid),
    .ready    (emit_req),
    .em_tag   (em_tag),
    .em_tid   (em_tid),
    .em_seq   (em_seq)
  );

  rwsb_pick #(.N(DEPTH)) u_emit (
    .req (emit_req),
    .gnt (emit_gnt),
    .any (emit_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_valid <= 1'b0;
      rdy_tag   <= '0;
      rdy_tid   <= '0;
      rdy_seq   <= '0;
    end else begin
      rdy_valid <= emit_any;
      rdy_tag   <= em_tag;
      rdy_tid   <= em_tid;
      rdy_seq   <= em_seq;
    end
  end

  // R9: stall only when every slot is occupied.
  p_stall_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> (&wt_valid));

  // R9: a stalled dispatch cannot add an entry.
  p_stalled_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_stall) |=> ($countones(wt_valid) <= $past($countones(wt_valid))));

  // R10: no more than one slot is emitted per cycle.
  p_emit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(emit_gnt));

  // R4: an out-of-range completion with no clear pending leaves the scoreboard alone.
  p_untracked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_trk && !dst_clr) |=> $stable(sb_ready));
endmodule

// File: tb/tb_regwake_scoreboard.sv
`timescale 1ns/1ps
module tb_regwake_scoreboard;
  localparam int unsigned NPREG = 32;
  localparam int unsigned REG_W = 6;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned TAG_W = 4;
  localparam int unsigned TID_W = 1;
  localparam int unsigned SEQ_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_dst_en = 1'b0, disp_src0_en = 1'b0, disp_src1_en = 1'b0;
  logic [TAG_W-1:0] disp_tag = '0;
  logic [TID_W-1:0] disp_tid = '0;
  logic [SEQ_W-1:0] disp_seq = '0;
  logic [REG_W-1:0] disp_dst = '0, disp_src0 = '0, disp_src1 = '0;
  logic disp_stall;
  logic cmpl_valid = 1'b0;
  logic [REG_W-1:0] cmpl_reg = '0;
  logic sq_valid = 1'b0;
  logic [TID_W-1:0] sq_tid = '0;
  logic [SEQ_W-1:0] sq_seq = '0;
  logic rdy_valid;
  logic [TAG_W-1:0] rdy_tag;
  logic [TID_W-1:0] rdy_tid;
  logic [SEQ_W-1:0] rdy_seq;
  logic [NPREG-1:0] sb_ready;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  regwake_scoreboard #(.NPREG(NPREG), .REG_W(REG_W), .DEPTH(DEPTH), .TAG_W(TAG_W),
                       .TID_W(TID_W), .SEQ_W(SEQ_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_tid(disp_tid), .disp_seq(disp_seq),
    .disp_dst_en(disp_dst_en), .disp_dst(disp_dst),
    .disp_src0_en(disp_src0_en), .disp_src0(disp_src0),
    .disp_src1_en(disp_src1_en), .disp_src1(disp_src1),
    .disp_stall(disp_stall),
    .cmpl_valid(cmpl_valid), .cmpl_reg(cmpl_reg),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .rdy_valid(rdy_valid), .rdy_tag(rdy_tag), .rdy_tid(rdy_tid), .rdy_seq(rdy_seq),
    .sb_ready(sb_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 1'b0; disp_dst_en = 1'b0; disp_src0_en = 1'b0; disp_src1_en = 1'b0;
    cmpl_valid = 1'b0; sq_valid = 1'b0;
  endtask

  task automatic set_disp(input int tag, input int tid, input int seq,
                          input logic de, input int d, input logic e0, input int s0,
                          input logic e1, input int s1);
    disp_valid = 1'b1; disp_tag = TAG_W'(tag); disp_tid = TID_W'(tid); disp_seq = SEQ_W'(seq);
    disp_dst_en = de; disp_dst = REG_W'(d);
    disp_src0_en = e0; disp_src0 = REG_W'(s0);
    disp_src1_en = e1; disp_src1 = REG_W'(s1);
  endtask

  task automatic complete(input int r);
    cmpl_valid = 1'b1; cmpl_reg = REG_W'(r);
    cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R1 scoreboard clear", 64'(sb_ready), 64'd0);
    chk("R1 no ready pulse", 64'(rdy_valid), 64'd0);
    chk("R1 no stall", 64'(disp_stall), 64'd0);
  endtask

  task automatic t_complete_and_untracked();
    complete(5);
    chk("R3 completion sets bit 5", 64'(sb_ready), 64'h20);
    complete(40);
    chk("R4 out-of-range completion", 64'(sb_ready), 64'h20);
    set_disp(9, 0, 1, 1'b1, 40, 1'b0, 0, 1'b0, 0);
    cyc(); idle();
    chk("R4 out-of-range destination", 64'(sb_ready), 64'h20);
    cyc();
    chk("R5 sourceless entry emitted", 64'({rdy_valid, rdy_tag}), 64'h19);
    cyc();
  endtask

  task automatic t_dst_clear();
    set_disp(2, 1, 7, 1'b1, 5, 1'b0, 0, 1'b0, 0);
    cyc(); idle();
    chk("R2 destination clears bit 5", 64'(sb_ready[5]), 64'd0);
    chk("R5 not yet emitted", 64'(rdy_valid), 64'd0);
    cyc();
    chk("R5 emitted tag/tid/seq", 64'({rdy_valid, rdy_tag, rdy_tid, rdy_seq}),
        64'({1'b1, 4'd2, 1'b1, 8'd7}));
    cyc();
    chk("R5 single pulse", 64'(rdy_valid), 64'd0);
  endtask

  task automatic t_ready_at_dispatch();
    complete(7);
    set_disp(4, 0, 3, 1'b0, 0, 1'b1, 7, 1'b1, 45);
    cyc(); idle();
    cyc();
    chk("R5 ready sources plus R4 untracked source", 64'({rdy_valid, rdy_tag}), 64'h14);
    cyc();
  endtask

  task automatic t_wakeup();
    set_disp(3, 1, 50, 1'b0, 0, 1'b1, 9, 1'b1, 10);
    cyc(); idle();
    cyc();
    chk("R6 waiting entry silent", 64'(rdy_valid), 64'd0);
    complete(9);
    chk("R3 bit 9 set", 64'(sb_ready[9]), 64'd1);
    cyc();
    chk("R6 one of two sources ready", 64'(rdy_valid), 64'd0);
    complete(10);
    chk("R6 not before edge after wake", 64'(rdy_valid), 64'd0);
    cyc();
    chk("R6 woken entry emitted", 64'({rdy_valid, rdy_tag, rdy_tid, rdy_seq}),
        64'({1'b1, 4'd3, 1'b1, 8'd50}));
    cyc();
  endtask

  task automatic t_forward();
    set_disp(6, 0, 60, 1'b0, 0, 1'b1, 11, 1'b0, 0);
    cmpl_valid = 1'b1; cmpl_reg = 6'd11;
    cyc(); idle();
    chk("R3 bit 11 set", 64'(sb_ready[11]), 64'd1);
    cyc();
    chk("R7 forwarded completion", 64'({rdy_valid, rdy_tag}), 64'h16);
    cyc();
  endtask

  task automatic t_dst_wins();
    complete(12);
    set_disp(8, 0, 61, 1'b1, 12, 1'b0, 0, 1'b0, 0);
    cmpl_valid = 1'b1; cmpl_reg = 6'd12;
    cyc(); idle();
    chk("R11 clear wins collision", 64'(sb_ready[12]), 64'd0);
    cyc();
    chk("R5 collision entry emitted", 64'({rdy_valid, rdy_tag}), 64'h18);
    cyc();
  endtask

  task automatic t_squash();
    set_disp(1, 0, 10, 1'b0, 0, 1'b1, 20, 1'b0, 0); cyc();
    set_disp(2, 0, 20, 1'b0, 0, 1'b1, 20, 1'b0, 0); cyc();
    set_disp(3, 1, 30, 1'b0, 0, 1'b1, 20, 1'b0, 0); cyc();
    set_disp(5, 0, 15, 1'b0, 0, 1'b1, 20, 1'b0, 0); cyc();
    idle();
    sq_valid = 1'b1; sq_tid = 1'b0; sq_seq = 8'd15;
    cyc(); idle();
    complete(20);
    chk("R8 nothing before wake edge", 64'(rdy_valid), 64'd0);
    cyc();
    chk("R8 older entry kept", 64'({rdy_valid, rdy_tag}), 64'h11);
    cyc();
    chk("R8 other thread kept", 64'({rdy_valid, rdy_tag}), 64'h13);
    cyc();
    chk("R8 equal sequence kept", 64'({rdy_valid, rdy_tag}), 64'h15);
    cyc();
    chk("R8 younger entry removed", 64'(rdy_valid), 64'd0);
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) begin
      set_disp(k, 0, 100 + k, 1'b0, 0, 1'b1, 21, 1'b0, 0);
      cyc();
    end
    idle();
    chk("R9 stall when full", 64'(disp_stall), 64'd1);
    set_disp(15, 0, 200, 1'b1, 7, 1'b0, 0, 1'b0, 0);
    cyc(); idle();
    chk("R9 stalled destination ignored", 64'(sb_ready[7]), 64'd1);
    chk("R9 still stalled", 64'(disp_stall), 64'd1);
    complete(21);
    for (int k = 0; k < DEPTH; k++) begin
      cyc();
      chk("R10 dispatch order emission", 64'({rdy_valid, rdy_tag}), 64'({1'b1, 4'(k)}));
    end
    cyc();
    chk("R9 stalled dispatch never emitted", 64'(rdy_valid), 64'd0);
    chk("R9 stall released", 64'(disp_stall), 64'd0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_complete_and_untracked();
    t_dst_clear();
    t_ready_at_dispatch();
    t_wakeup();
    t_forward();
    t_dst_wins();
    t_squash();
    t_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule